// File: doc/BRIEF.md
# Multi-Channel DMA Request Arbiter and Descriptor Loader

This block is the front end of a multi-channel DMA engine. A channel asks for service through a hardware request line from its peripheral or through a software start bit kept in its descriptor. Both sources go into one per-channel pending register. While the loader is idle, a single arbitration stage picks one pending channel. The choice is by fixed priority or by round-robin, and the `rr_mode` input selects between them at run time.

The winning channel number is turned into the base address of that channel's 256-bit descriptor in a 64-bit-wide local memory. The loader reads the descriptor as four beats into the engine's working register. It then raises `desc_valid` and waits for the engine's `eng_done` before it arbitrates again. When a load finishes, the winner's pending flag is cleared.

Top module: `dma_chan_arb_fetch`

## Requirements
- R1: A high `hw_req[c]` is stored in the pending register at the next rising edge E. If the block is idle at E, the grant is taken at edge E+1 and the first descriptor read is issued in the cycle after E+1.
- R2: A high `sw_start[c]` sets the same pending flag as `hw_req[c]`, with identical timing and identical service.
- R3: With `rr_mode`=0, the highest-numbered pending channel wins.
- R4: With `rr_mode`=1, the search starts at the channel just above the last winner and wraps from NCH-1 to 0. Every grant, in either mode, updates the last winner. After reset the last winner is NCH-1, so the first search starts at channel 0.
- R5: `rr_mode` is sampled in the arbitration cycle, so switching it between services changes the pick from the next service onward.
- R6: A load issues `mem_rd_en` for four consecutive cycles. The addresses are channel*4+0, +1, +2 and +3, in that order.
- R7: The memory returns data one cycle after each read. Beat k is stored in `desc_data[64k+63:64k]`, and `desc_chan` carries the served channel.
- R8: `desc_valid` rises one cycle after the last beat returns, which is edge E+6 counted from R1. It stays high, with `desc_data` unchanged, until `eng_done` is sampled high. No new arbitration happens while it is high. The next grant can be taken at the edge after the `eng_done` edge.
- R9: The served channel's pending flag is cleared on the edge where `desc_valid` rises. Requests that arrive during a load stay pending and are served later.
- R10: After reset, `mem_rd_en` and `desc_valid` are low. While nothing is pending, the block issues no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | NCH | Per-channel peripheral request lines |
| sw_start | input | NCH | Per-channel software start bits, taken from the descriptors |
| rr_mode | input | 1 | 1 selects round-robin, 0 selects fixed priority |
| eng_done | input | 1 | The engine has consumed the loaded descriptor |
| mem_rd_en | output | 1 | Descriptor memory read enable |
| mem_addr | output | log2(NCH)+2 | Descriptor memory beat address |
| mem_rd_data | input | 64 | Read data, valid one cycle after `mem_rd_en` |
| desc_valid | output | 1 | The engine working register holds a complete descriptor |
| desc_chan | output | log2(NCH) | Channel whose descriptor is loaded |
| desc_data | output | 256 | Engine working register, four 64-bit beats |

## Verification
All results are timed from the edge E at which a request is stored in the pending register, or from the `eng_done` edge when the block returns to idle. The four read addresses are due in the cycles after E+1 through E+4. The bus is quiet after E+5, and `desc_valid` with the full descriptor is due after E+6. The bench samples at the falling edge that lies exactly that many edges after the stimulus. It predicts the winner with its own model of the pending set and the last winner, and it builds the expected descriptor from the same address-derived pattern that its memory model returns.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int BEAT_W     = 64;
  localparam int DESC_BEATS = 4;
  localparam int MAX_CH     = 64;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DRAIN, ST_HOLD} fetch_st_t;

  // Highest set index of a pending vector (fixed priority).
  function automatic logic [5:0] pick_fixed(logic [MAX_CH-1:0] p);
    logic [5:0] r;
    r = '0;
    for (int i = 0; i < MAX_CH; i++)
      if (p[i]) r = 6'(i);
    return r;
  endfunction

  // First set index found when scanning upward from last+1, modulo n.
  function automatic logic [5:0] pick_rr(logic [MAX_CH-1:0] p, logic [5:0] last, int n);
    logic [5:0] r;
    logic       hit;
    int         idx;
    r   = last;
    hit = 1'b0;
    for (int k = 1; k <= MAX_CH; k++) begin
      idx = (int'(last) + k) % n;
      if (!hit && k <= n && p[idx]) begin
        r   = 6'(idx);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  // Descriptor base address: channel times the beats per descriptor.
  function automatic logic [7:0] desc_base(logic [5:0] ch);
    return {ch, 2'b00};
  endfunction
endpackage

// File: rtl/dma_req_capture.sv
module dma_req_capture #(
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hw_req,
  input  logic [NCH-1:0] sw_start,
  input  logic           clr_en,
  input  logic [CW-1:0]  clr_chan,
  output logic [NCH-1:0] pend
);
  logic [NCH-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask[clr_chan] = 1'b1;
  end

  // Both request sources share one registered path; a clear wins over a new set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend | hw_req | sw_start) & ~clr_mask;
  end

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !pend[$past(clr_chan)]);
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pend,
  input  logic           arb_en,
  input  logic           rr_mode,
  output logic           grant,
  output logic [CW-1:0]  win
);
  logic [CW-1:0]     last_q;
  logic [MAX_CH-1:0] pend_w;
  logic [5:0]        pick_f, pick_r;

  assign pend_w = MAX_CH'(pend);
  assign pick_f = pick_fixed(pend_w);
  assign pick_r = pick_rr(pend_w, 6'(last_q), NCH);
  assign grant  = arb_en && (|pend);
  assign win    = rr_mode ? CW'(pick_r) : CW'(pick_f);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_q <= CW'(NCH - 1);
    else if (grant) last_q <= win;
  end

  p_win_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> pend[win]);
  p_fixed_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !rr_mode) |-> ((pend >> win) == NCH'(1)));
  p_rr_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && rr_mode && (pend != (NCH'(1) << last_q))) |-> (win != last_q));
endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_arb_pkg::*;
#(
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH),
  localparam int AW = CW + $clog2(DESC_BEATS),
  localparam int DW = BEAT_W * DESC_BEATS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  input  logic [CW-1:0]     win,
  input  logic              eng_done,
  input  logic [BEAT_W-1:0] mem_rd_data,
  output logic              idle,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_addr,
  output logic              load_done,
  output logic              desc_valid,
  output logic [CW-1:0]     desc_chan,
  output logic [DW-1:0]     desc_data
);
  localparam int BTW = $clog2(DESC_BEATS);
  localparam logic [BTW-1:0] LAST_BEAT = BTW'(DESC_BEATS - 1);

  fetch_st_t      st_q;
  logic [CW-1:0]  win_q;
  logic [BTW-1:0] beat_q, rd_beat_q;
  logic           rd_vld_q;

  assign idle      = (st_q == ST_IDLE);
  assign mem_rd_en = (st_q == ST_FETCH);
  assign mem_addr  = AW'(desc_base(6'(win_q))) + AW'(beat_q);
  assign load_done = (st_q == ST_DRAIN) && rd_vld_q && (rd_beat_q == LAST_BEAT);
  assign desc_chan = win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      win_q      <= '0;
      beat_q     <= '0;
      rd_beat_q  <= '0;
      rd_vld_q   <= 1'b0;
      desc_valid <= 1'b0;
      desc_data  <= '0;
    end else begin
      rd_vld_q  <= mem_rd_en;
      rd_beat_q <= beat_q;
      if (rd_vld_q) desc_data[int'(rd_beat_q)*BEAT_W +: BEAT_W] <= mem_rd_data;
      unique case (st_q)
        ST_IDLE: if (grant) begin
          win_q  <= win;
          beat_q <= '0;
          st_q   <= ST_FETCH;
        end
        ST_FETCH: begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) st_q <= ST_DRAIN;
        end
        ST_DRAIN: if (load_done) begin
          desc_valid <= 1'b1;
          st_q       <= ST_HOLD;
        end
        ST_HOLD: if (eng_done) begin
          desc_valid <= 1'b0;
          st_q       <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_beat_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));
  p_first_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_en) |-> $past(grant));
  p_hold_desc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !eng_done) |=> (desc_valid && $stable(desc_data) && $stable(desc_chan)));
  p_no_read_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> !mem_rd_en);
endmodule

// File: rtl/dma_chan_arb_fetch.sv
module dma_chan_arb_fetch
  import dma_arb_pkg::*;
#(
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH),
  localparam int AW = CW + $clog2(DESC_BEATS),
  localparam int DW = BEAT_W * DESC_BEATS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    hw_req,
  input  logic [NCH-1:0]    sw_start,
  input  logic              rr_mode,
  input  logic              eng_done,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_addr,
  input  logic [BEAT_W-1:0] mem_rd_data,
  output logic              desc_valid,
  output logic [CW-1:0]     desc_chan,
  output logic [DW-1:0]     desc_data
);
  if (NCH != 32 && NCH != 64) begin : g_bad_nch
    initial $error("NCH must be 32 or 64");
  end

  logic [NCH-1:0] pend;
  logic           grant, idle, load_done;
  logic [CW-1:0]  win;

  dma_req_capture #(.NCH(NCH)) u_cap (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_start(sw_start),
    .clr_en(load_done), .clr_chan(desc_chan), .pend(pend));

  dma_chan_arbiter #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .arb_en(idle), .rr_mode(rr_mode),
    .grant(grant), .win(win));

  dma_desc_fetch #(.NCH(NCH)) u_fetch (
    .clk(clk), .rst_n(rst_n), .grant(grant), .win(win), .eng_done(eng_done),
    .mem_rd_data(mem_rd_data), .idle(idle), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .load_done(load_done), .desc_valid(desc_valid),
    .desc_chan(desc_chan), .desc_data(desc_data));

  p_cleared_at_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desc_valid) |-> !pend[desc_chan]);
  p_quiet_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pend == '0) |=> !mem_rd_en);
endmodule

// File: tb/dma_chan_arb_fetch_tb.sv
module dma_chan_arb_fetch_tb_top;
  localparam int NCH = 32;
  localparam int CW  = $clog2(NCH);
  localparam int AW  = CW + 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] hw_req = '0, sw_start = '0;
  logic           rr_mode = 1'b0, eng_done = 1'b0;
  logic           mem_rd_en, desc_valid;
  logic [AW-1:0]  mem_addr;
  logic [63:0]    mem_rd_data = '0;
  logic [CW-1:0]  desc_chan;
  logic [255:0]   desc_data;

  int n_chk = 0, n_bad = 0;
  logic [NCH-1:0] m_pend = '0;
  int             m_last = NCH - 1;
  bit             finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_chan_arb_fetch #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_start(sw_start),
    .rr_mode(rr_mode), .eng_done(eng_done), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .desc_valid(desc_valid),
    .desc_chan(desc_chan), .desc_data(desc_data));

  function automatic logic [63:0] pat(int a);
    return {8'hA5, 24'(a), (32'(a) * 32'h0100_0193) ^ 32'h5BD1_E995};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= pat(int'(mem_addr));

  task automatic chk(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_pick();
    if (rr_mode) begin
      for (int k = 1; k <= NCH; k++)
        if (m_pend[(m_last + k) % NCH]) return (m_last + k) % NCH;
    end else begin
      for (int c = NCH - 1; c >= 0; c--)
        if (m_pend[c]) return c;
    end
    return -1;
  endfunction

  task automatic pulse(logic [NCH-1:0] hw, logic [NCH-1:0] sw);
    @(negedge clk);
    hw_req = hw; sw_start = sw;
    @(negedge clk);
    hw_req = '0; sw_start = '0;
    m_pend |= hw | sw;
  endtask

  // Called at the falling edge right after the block can arbitrate (edge E).
  task automatic service(logic [NCH-1:0] inject, int hold, string tag);
    int exp;
    logic [255:0] ed;
    exp = model_pick();
    m_last = exp;
    hw_req = inject;
    @(negedge clk);
    hw_req = '0;
    m_pend |= inject;
    chk(mem_rd_en && mem_addr == AW'(exp * 4), {tag, " R1 R6 beat0"}, 256'(mem_addr), 256'(exp * 4));
    for (int b = 1; b < 4; b++) begin
      @(negedge clk);
      chk(mem_rd_en && mem_addr == AW'(exp * 4 + b), "R6 beat", 256'(mem_addr), 256'(exp * 4 + b));
    end
    @(negedge clk);
    chk(!mem_rd_en && !desc_valid, "R8 early", 256'({mem_rd_en, desc_valid}), 256'(0));
    @(negedge clk);
    ed = {pat(exp * 4 + 3), pat(exp * 4 + 2), pat(exp * 4 + 1), pat(exp * 4)};
    chk(desc_valid && desc_chan == CW'(exp), {tag, " R3 R4 R8 chan"}, 256'(desc_chan), 256'(exp));
    chk(desc_data == ed, "R7 data", desc_data, ed);
    m_pend[exp] = 1'b0;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(desc_valid && !mem_rd_en && desc_data == ed, "R8 hold", desc_data, ed);
    end
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    chk(!desc_valid, "R8 release", 256'(desc_valid), 256'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!mem_rd_en && !desc_valid, "R10 reset", 256'({mem_rd_en, desc_valid}), 256'(0));
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk(!mem_rd_en, "R10 idle", 256'(mem_rd_en), 256'(0));
    end
    // R1/R2: each channel alone, odd channels through the software start bit
    rr_mode = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (c % 2 == 1) pulse('0, NCH'(1) << c);
      else            pulse(NCH'(1) << c, '0);
      service('0, 0, (c % 2 == 1) ? "R2 sw" : "R1 hw");
    end
    // R3: everything pending at once, fixed priority
    pulse('1, '0);
    for (int i = 0; i < NCH; i++) service('0, 0, "R3 fixed");
    // R4: everything pending, round-robin with wrap
    rr_mode = 1'b1;
    pulse('0, '1);
    for (int i = 0; i < NCH; i++) service('0, 0, "R4 rr");
    // R5: switch modes between services on a sparse set
    pulse(32'hF00F_0C30, '0);
    for (int i = 0; i < 10; i++) begin
      rr_mode = (i % 3 != 0);
      service('0, 0, "R5 switch");
    end
    while (m_pend != '0) service('0, 0, "R5 drain");
    // R9: request arriving during a load stays pending; R8 long hold
    rr_mode = 1'b0;
    pulse(NCH'(1) << 3, '0);
    service(NCH'(1) << 7, 3, "R9 first");
    chk(m_pend == (NCH'(1) << 7), "R9 model", 256'(m_pend), 256'(NCH'(1) << 7));
    service('0, 0, "R9 retained");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!mem_rd_en, "R10 empty after", 256'(mem_rd_en), 256'(0));
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule